// File: doc/BRIEF.md
# T1 Extended Superframe Transmit Framer with Payload Loopback

This block builds the serial transmit bit stream for a T1 line that uses Extended Superframe framing. Each frame is 193 bits long: one overhead bit followed by 24 channels of 8 payload bits. Twenty-four frames make a superframe. The overhead bit carries one of three things. In frames 4, 8, 12, 16, 20 and 24 it carries the framing pattern. In frames 2, 6, 10, 14, 18 and 22 it carries a CRC-6 check bit. In the odd frames it carries a data-link bit taken from a separate input. The block generates all overhead bits locally in every mode.

The block runs on one clock. Bit timing comes from two single-cycle enables: one for the transmit side and one for the receive side. In normal mode the payload comes from the transmit serial input, and bits advance on the transmit enable. In payload loopback mode the payload comes from the receive path, which has already been decoded and corrected for bipolar violations, and bits advance on the receive enable. In loopback the transmit serial input is ignored and the channel strobes are held low. A loopback request takes effect only when a superframe completes, so frame alignment is never broken.

In loopback the receive path is expected to present its corrected payload bit aligned with the transmit bit position. The receive-side logic itself lies outside this block.

Top module: `esf_tx_framer`

## Requirements
- R1: While reset is held, and after it until the first bit step, `txOut`, `txLineEn`, `txChanClk`, `txChanBlk` and `loopActive` are all 0. The first bit emitted after reset is the overhead bit of frame 1 of a superframe.
- R2: Each bit step emits one bit. The active enable is `txBitEn` in normal mode and `rxBitEn` in loopback. Frame slot 0 is the overhead bit and slots 1..192 are payload. In normal mode a payload slot carries the `txSer` value sampled on the enable cycle. `txOut` shows the bit from the clock after the enable and holds it until the next step.
- R3: The overhead bits of frames 4, 8, 12, 16, 20 and 24 carry the framing pattern 0, 0, 1, 0, 1, 1, in that frame order.
- R4: The overhead bit of each odd frame (1, 3, ..., 23) carries the `dlBit` value sampled on that bit's enable cycle.
- R5: The overhead bits of frames 2, 6, 10, 14, 18 and 22 carry the check bits C1..C6, in that order. These bits are the remainder of (previous superframe's 4632 bits × x^6) modulo x^6+x+1. The superframe's bits are taken in transmit order, with every overhead bit counted as 1. C1 is the most significant remainder coefficient. During the first superframe after reset the check bits are 0.
- R6: A change on `loopEnReq` takes effect only on the step that completes bit 192 of frame 24. `loopActive` follows one clock later and otherwise stays constant.
- R7: In loopback each payload slot carries the `rxPayBit` value sampled on the `rxBitEn` cycle. `txSer` has no effect on `txOut`.
- R8: `txLineEn` is a one-cycle pulse, one clock after each step of the active enable. A pulse on the inactive enable does not advance the frame position, does not change `txOut`, and raises no `txLineEn`.
- R9: In normal mode, after the step that emits the first bit of any channel (slots 1, 9, ..., 185), `txChanClk` is 1; after every other step it is 0. `txChanBlk` is 1 only after the step that emits the overhead bit of frame 1. In loopback both are held at 0.
- R10: In loopback the framing pattern, check bits and data-link bits are still generated as in R3 to R5. The check bits are computed over the bits actually transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBitEn | input | 1 | Transmit bit-timing enable, one cycle per bit |
| rxBitEn | input | 1 | Receive bit-timing enable, one cycle per bit |
| txSer | input | 1 | Transmit serial payload bit |
| rxPayBit | input | 1 | Corrected received payload bit for loopback |
| dlBit | input | 1 | Data-link bit for odd-frame overhead slots |
| loopEnReq | input | 1 | Payload loopback request, applied at superframe end |
| txOut | output | 1 | Framed transmit bit |
| txLineEn | output | 1 | Line clock enable, pulses when txOut updates |
| txChanClk | output | 1 | First-bit-of-channel strobe |
| txChanBlk | output | 1 | Superframe start strobe (frame 1 overhead bit) |
| loopActive | output | 1 | Loopback currently in force |

## Verification
A slip in the frame or superframe counter shows up at once on the ports. A framing-pattern or data-link bit appears in the wrong overhead slot, or `txChanClk` lands off a channel boundary, within one frame at most. A wrong running CRC stays hidden until the next superframe, when frames 2 to 22 carry the bad check bits. The bench therefore recomputes the remainder itself, with long division, and checks every overhead bit across several superframes. A loopback switch taken at the wrong moment changes `loopActive` and the payload source in the middle of a superframe. Every bit also exercises the inactive enable, so a mis-selected timing source moves `txLineEn` or `txOut` one clock later.

// File: rtl/esf_pkg.sv
package esf_pkg;

  typedef enum logic [1:0] {
    OH_DATALINK = 2'd0,
    OH_CHECK    = 2'd1,
    OH_PATTERN  = 2'd2
  } ohKind_t;

  // Strobes from the sequencer to the bit datapath, valid in the step cycle.
  typedef struct packed {
    logic    step;       // one bit slot is emitted this cycle
    logic    loop;       // loopback mode of the slot being emitted
    logic    isOh;       // slot is the overhead bit
    ohKind_t ohKind;     // which overhead stream owns the slot
    logic [2:0] ohSel;   // index of the bit within its 6-bit stream
    logic    chanFirst;  // slot is the first bit of a channel
    logic    sfStart;    // slot is the overhead bit of frame 1
    logic    sfEnd;      // slot is the last bit of the superframe
  } seqStrobes_t;

endpackage

// File: rtl/esf_seq.sv
module esf_seq
  import esf_pkg::*;
#(
  parameter int CHANNELS  = 24,
  parameter int CHAN_BITS = 8,
  parameter int FRAMES    = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txBitEn,
  input  logic        rxBitEn,
  input  logic        loopEnReq,
  output seqStrobes_t seq,
  output logic        loopActive
);
  localparam int FRAME_BITS = CHANNELS * CHAN_BITS + 1;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int FR_W       = $clog2(FRAMES);

  logic [BIT_W-1:0] bitIdx;
  logic [FR_W-1:0]  frameIdx;
  logic             stepNow;
  logic             lastBit;
  logic             lastFrame;
  logic [BIT_W-1:0] payPos;

  // Timing source follows the mode in force for the current slot.
  assign stepNow   = loopActive ? rxBitEn : txBitEn;
  assign lastBit   = (bitIdx == BIT_W'(FRAME_BITS - 1));
  assign lastFrame = (frameIdx == FR_W'(FRAMES - 1));
  assign payPos    = bitIdx - BIT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx     <= '0;
      frameIdx   <= '0;
      loopActive <= 1'b0;
    end else if (stepNow) begin
      if (lastBit) begin
        bitIdx <= '0;
        if (lastFrame) begin
          frameIdx   <= '0;
          loopActive <= loopEnReq;
        end else begin
          frameIdx <= frameIdx + FR_W'(1);
        end
      end else begin
        bitIdx <= bitIdx + BIT_W'(1);
      end
    end
  end

  always_comb begin
    seq.step      = stepNow;
    seq.loop      = loopActive;
    seq.isOh      = (bitIdx == '0);
    seq.ohSel     = 3'(frameIdx >> 2);
    unique case (frameIdx[1:0])
      2'd3:    seq.ohKind = OH_PATTERN;
      2'd1:    seq.ohKind = OH_CHECK;
      default: seq.ohKind = OH_DATALINK;
    endcase
    seq.chanFirst = (bitIdx != '0) &&
                    ((payPos % BIT_W'(CHAN_BITS)) == '0);
    seq.sfStart   = (bitIdx == '0) && (frameIdx == '0);
    seq.sfEnd     = stepNow && lastBit && lastFrame;
  end

  AST_LOOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(loopActive) |-> $past(seq.sfEnd)); // R6

  AST_STEP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bitIdx) |-> $past(loopActive ? rxBitEn : txBitEn)); // R8

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx < BIT_W'(FRAME_BITS)) && (frameIdx < FR_W'(FRAMES))); // R2

endmodule

// File: rtl/esf_bitpath.sv
module esf_bitpath
  import esf_pkg::*;
#(
  parameter int             CRC_W    = 6,
  parameter logic [CRC_W-1:0] CRC_POLY = 6'b000011,
  parameter logic [5:0]       FPS_PAT  = 6'b110100
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t seq,
  input  logic        txSer,
  input  logic        rxPayBit,
  input  logic        dlBit,
  output logic        txOut,
  output logic        txLineEn,
  output logic        txChanClk,
  output logic        txChanBlk
);
  logic [CRC_W-1:0] crcRun;
  logic [CRC_W-1:0] crcHeld;
  logic [CRC_W-1:0] crcNext;
  logic             ohBit;
  logic             slotBit;
  logic             crcIn;

  always_comb begin
    unique case (seq.ohKind)
      OH_PATTERN: ohBit = FPS_PAT[seq.ohSel];
      OH_CHECK:   ohBit = crcHeld[CRC_W - 1 - int'(seq.ohSel)];
      default:    ohBit = dlBit;
    endcase
  end

  assign slotBit = seq.isOh ? ohBit : (seq.loop ? rxPayBit : txSer);
  // Overhead slots enter the check sum as 1.
  assign crcIn   = seq.isOh ? 1'b1 : slotBit;
  assign crcNext = {crcRun[CRC_W-2:0], 1'b0} ^
                   ((crcIn ^ crcRun[CRC_W-1]) ? CRC_POLY : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOut     <= 1'b0;
      txLineEn  <= 1'b0;
      txChanClk <= 1'b0;
      txChanBlk <= 1'b0;
      crcRun    <= '0;
      crcHeld   <= '0;
    end else begin
      txLineEn <= seq.step;
      if (seq.step) begin
        txOut     <= slotBit;
        txChanClk <= !seq.loop && seq.chanFirst;
        txChanBlk <= !seq.loop && seq.sfStart;
        if (seq.sfEnd) begin
          crcHeld <= crcNext;
          crcRun  <= '0;
        end else begin
          crcRun <= crcNext;
        end
      end
    end
  end

  AST_QUIET_STROBES_IN_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    seq.loop |-> (!txChanClk && !txChanBlk)); // R9

  AST_CHECK_HELD_PER_SF: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(crcHeld) |-> $past(seq.sfEnd)); // R5

  AST_OUT_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txOut) |-> txLineEn); // R8

endmodule

// File: rtl/esf_tx_framer.sv
module esf_tx_framer
  import esf_pkg::*;
#(
  parameter int CHANNELS  = 24,
  parameter int CHAN_BITS = 8,
  parameter int FRAMES    = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic txBitEn,
  input  logic rxBitEn,
  input  logic txSer,
  input  logic rxPayBit,
  input  logic dlBit,
  input  logic loopEnReq,
  output logic txOut,
  output logic txLineEn,
  output logic txChanClk,
  output logic txChanBlk,
  output logic loopActive
);
  seqStrobes_t seq;

  esf_seq #(
    .CHANNELS (CHANNELS),
    .CHAN_BITS(CHAN_BITS),
    .FRAMES   (FRAMES)
  ) seq_i (
    .clk       (clk),
    .rstN      (rstN),
    .txBitEn   (txBitEn),
    .rxBitEn   (rxBitEn),
    .loopEnReq (loopEnReq),
    .seq       (seq),
    .loopActive(loopActive)
  );

  esf_bitpath bitpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .seq      (seq),
    .txSer    (txSer),
    .rxPayBit (rxPayBit),
    .dlBit    (dlBit),
    .txOut    (txOut),
    .txLineEn (txLineEn),
    .txChanClk(txChanClk),
    .txChanBlk(txChanBlk)
  );

endmodule

// File: tb/esf_tx_framer_tb.sv
module esf_tx_framer_tb_top;
  localparam int FBITS  = 193;
  localparam int NFR    = 24;
  localparam int SFBITS = FBITS * NFR;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txBitEn = 1'b0, rxBitEn = 1'b0, txSer = 1'b0, rxPayBit = 1'b0;
  logic dlBit = 1'b0, loopEnReq = 1'b0;
  logic txOut, txLineEn, txChanClk, txChanBlk, loopActive;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // bench-side model state
  int   bp = 0, bf = 0;
  bit   bLoop = 1'b0;
  bit   sfBits [SFBITS];
  logic [5:0] crcPrev = '0;
  bit   patt [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  always #2 clk = ~clk;

  esf_tx_framer dut_i (
    .clk(clk), .rstN(rstN), .txBitEn(txBitEn), .rxBitEn(rxBitEn),
    .txSer(txSer), .rxPayBit(rxPayBit), .dlBit(dlBit), .loopEnReq(loopEnReq),
    .txOut(txOut), .txLineEn(txLineEn), .txChanClk(txChanClk),
    .txChanBlk(txChanBlk), .loopActive(loopActive)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (frame %0d slot %0d)",
               req, act, exp, bf + 1, bp);
    end
  endtask

  // Remainder of (bits * x^6) mod x^6+x+1 by plain long division.
  task automatic computeCheck();
    logic [6:0] r = '0;
    for (int i = 0; i < SFBITS + 6; i++) begin
      r = {r[5:0], (i < SFBITS) ? sfBits[i] : 1'b0};
      if (r[6]) r = r ^ 7'h43;
    end
    crcPrev = r[5:0];
  endtask

  task automatic doBit();
    bit ser = 1'($urandom);
    bit rx  = 1'($urandom);
    bit dl  = 1'($urandom);
    bit slotLoop = bLoop;
    int n = bf + 1;
    bit exp;
    string tag;
    if (bp == 0) begin
      if (n % 4 == 0) begin exp = patt[n/4 - 1]; tag = "R3"; end
      else if (n % 4 == 2) begin exp = crcPrev[5 - (n-2)/4]; tag = "R5"; end
      else begin exp = dl; tag = "R4"; end
      if (slotLoop) tag = {tag, "/R10"};
    end else begin
      exp = slotLoop ? rx : ser;
      tag = slotLoop ? "R7" : "R2";
    end
    @(negedge clk);
    txSer = ser; rxPayBit = rx; dlBit = dl;
    if (slotLoop) rxBitEn = 1'b1; else txBitEn = 1'b1;
    @(negedge clk);
    rxBitEn = 1'b0; txBitEn = 1'b0;
    chk(tag, txOut, exp);
    chk("R8 line enable pulse", txLineEn, 1'b1);
    chk("R9 chan clk", txChanClk, !slotLoop && bp != 0 && ((bp - 1) % 8 == 0));
    chk("R9 chan blk", txChanBlk, !slotLoop && bp == 0 && bf == 0);
    sfBits[bf*FBITS + bp] = (bp == 0) ? 1'b1 : exp;
    if (bp == FBITS - 1) begin
      bp = 0;
      if (bf == NFR - 1) begin
        bf = 0;
        bLoop = loopEnReq;
        computeCheck();
      end else bf++;
    end else bp++;
    chk("R6 loop state", loopActive, bLoop);
    // pulse the inactive enable with inverted data: must be ignored
    txSer = ~ser; rxPayBit = ~rx; dlBit = ~dl;
    if (bLoop) txBitEn = 1'b1; else rxBitEn = 1'b1;
    @(negedge clk);
    txBitEn = 1'b0; rxBitEn = 1'b0;
    chk("R8 inactive enable no pulse", txLineEn, 1'b0);
    chk("R8/R7 inactive enable keeps bit", txOut, exp);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 txOut", txOut, 1'b0);
    chk("R1 txLineEn", txLineEn, 1'b0);
    chk("R1 txChanClk", txChanClk, 1'b0);
    chk("R1 txChanBlk", txChanBlk, 1'b0);
    chk("R1 loopActive", loopActive, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", txLineEn, 1'b0);
    chk("R1 idle loopActive", loopActive, 1'b0);
  endtask

  // One superframe; the loop request is changed part-way through it.
  task automatic runSuperframe(bit reqVal, int reqAt);
    for (int i = 0; i < SFBITS; i++) begin
      if (i == reqAt) loopEnReq = reqVal;
      doBit();
    end
  endtask

  initial begin
    testReset();
    runSuperframe(1'b0, 10);    // normal, first check bits all zero (R5)
    runSuperframe(1'b1, 2000);  // request mid-superframe: no effect yet (R6)
    runSuperframe(1'b1, 5);     // looped superframe (R7, R8, R9, R10)
    runSuperframe(1'b0, 100);   // release request mid-loop (R6)
    runSuperframe(1'b0, 0);     // back to normal timing (R2)
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule